// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns parallel characters into an asynchronous-style serial frame on a single output line. Each frame carries a low start bit, then 5 to 9 data bits, then an optional parity bit, then one, one and a half or two high stop bits. The block steps on a timing strobe (`tick`) supplied by an external rate generator. In asynchronous mode that strobe is a 16x oversampling tick, so each bit lasts 16 ticks. In synchronous mode each tick is one whole bit.

Characters arrive on a valid/ready stream port. Behind the port is a single holding slot, and behind that is the shift register. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is enabled and the holding slot is empty. A beat offered while `in_ready` is low is not taken and leaves no trace, so a source that wants it delivered must hold it. When the shifter is idle and the slot is full, the slot's character moves into the shifter on the next clock and `in_ready` rises again. `tx_empty` reports that the slot and the shifter are both empty.

The mode inputs are sampled when a character enters the shifter. They should be held steady while a character waits in the holding slot.

Top module: `frame_tx`

## Requirements
- R1: After reset, and before the first clock edge with `en` high, `txd` is 1 and both `in_ready` and `tx_empty` are 0. One clock edge after `en` is set, both flags are 1. `txd` is 1 whenever no frame is in progress.
- R2: A frame is one 0 start bit, then the data bits, then the parity bit if one is enabled, then the stop bits at 1. In asynchronous mode (`sync_mode`=0) each bit lasts 16 ticks. In synchronous mode (`sync_mode`=1) each bit lasts 1 tick. The start bit is on `txd` from the clock edge that loads the shifter.
- R3: With `nine_bit`=0, the data length is `len_sel`+5: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `in_data` above that length are not sent.
- R4: With `nine_bit`=1, 9 data bits are sent whatever the value of `len_sel`.
- R5: `par_sel` selects the parity bit: 0 even (the parity bit makes the count of ones over data and parity even), 1 odd, 2 always 0, 3 always 1, and 4 to 7 no parity bit. Parity covers only the data bits that are sent.
- R6: With `msb_first`=0, `in_data[0]` goes first. With `msb_first`=1, the highest sent data bit (bit length-1) goes first.
- R7: `stop_sel` selects the stop bits: 0 gives one, 2 gives two, and 1 gives one and a half in asynchronous mode (24 ticks of 1) but one in synchronous mode. The value 3 gives one.
- R8: After an accepted beat, `in_ready` is 0 at the next clock edge. When the shifter is idle, the held character moves into it on the following edge, and `in_ready` returns to 1.
- R9: `tx_empty` is 1 only when the block is enabled, the holding slot is empty and no frame is being shifted.
- R10: A beat offered while `in_ready` is 0 is dropped. It never appears on `txd`, and the held character is unchanged.
- R11: `en` set to 0 stops any frame in progress and clears the holding slot at the next clock edge. From that edge, `in_ready` and `tx_empty` are 0 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmitter enable |
| tick | input | 1 | Bit-timing strobe, one clock wide |
| len_sel | input | 2 | Data length select (length = value + 5) |
| nine_bit | input | 1 | Forces 9 data bits |
| par_sel | input | 3 | Parity select |
| msb_first | input | 1 | Bit order: 1 sends the MSB first |
| stop_sel | input | 2 | Stop-bit select |
| sync_mode | input | 1 | 1 = one tick per bit, 0 = 16 ticks per bit |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Holding slot can take a beat |
| in_data | input | 9 | Character to send |
| txd | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Slot and shifter both empty |

## Verification
The hardest case to reach is a dropped beat. It needs the holding slot to be full while the shifter is busy, so the bench sends one character, sends a second one the moment `in_ready` returns, and then offers a third at once. It then checks that the serial stream holds only the first two frames. For that sequence the bench pulses `tick` on every clock, which makes the one idle clock between the two frames land on a known tick. The one-and-a-half stop case is also hard to see from outside: its last stop bit is half length, which shows only as the exact tick count of the frame. The bench therefore compares whole frames tick by tick against a frame it builds itself, under both directed and randomly drawn modes and tick spacings.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef struct packed {
    logic [1:0] len;
    logic       nine;
    logic [2:0] par;
    logic       msb;
    logic [1:0] stop;
    logic       sync;
  } tx_mode_t;

  localparam logic [2:0] PAR_EVEN  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_ZERO  = 3'd2;
  localparam logic [2:0] PAR_ONE   = 3'd3;

  localparam logic [1:0] STOP_ONE  = 2'd0;
  localparam logic [1:0] STOP_HALF = 2'd1;
  localparam logic [1:0] STOP_TWO  = 2'd2;

endpackage

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                en_q,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  input  logic                take,
  output logic                full,
  output logic                ready,
  output logic [DATA_MAX-1:0] data
);

  logic accept;

  assign ready  = en_q & ~full;
  assign accept = in_valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_tx_fmt.sv
module frame_tx_fmt
  import frame_tx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int FRAME_W  = DATA_MAX + 4,
  parameter int NB_W     = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_MAX-1:0] data,
  input  tx_mode_t            mode,
  output logic [FRAME_W-1:0]  frame,
  output logic [NB_W-1:0]     nbits,
  output logic                half_last
);

  localparam int IDX_W = $clog2(DATA_MAX);
  localparam int POS_W = $clog2(FRAME_W);

  logic [NB_W-1:0]     nd;
  logic [DATA_MAX-1:0] masked;
  logic [DATA_MAX-1:0] ordered;
  logic [IDX_W-1:0]    src;
  logic [POS_W-1:0]    ppos;
  logic                par_on;
  logic                pval;
  logic                two;

  always_comb begin
    nd      = mode.nine ? NB_W'(DATA_MAX) : NB_W'(mode.len) + NB_W'(5);
    par_on  = (mode.par[2] == 1'b0);
    masked  = '0;
    ordered = '0;
    src     = '0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nd)) begin
        masked[i]  = data[i];
        src        = IDX_W'(int'(nd) - 1 - i);
        ordered[i] = mode.msb ? data[src] : data[i];
      end
    end
    case (mode.par)
      PAR_EVEN: pval = ^masked;
      PAR_ODD:  pval = ~(^masked);
      PAR_ZERO: pval = 1'b0;
      PAR_ONE:  pval = 1'b1;
      default:  pval = 1'b1;
    endcase
    two       = (mode.stop == STOP_TWO) || ((mode.stop == STOP_HALF) && !mode.sync);
    half_last = (mode.stop == STOP_HALF) && !mode.sync;
    frame     = '1;
    frame[0]  = 1'b0;
    for (int k = 0; k < DATA_MAX; k++) begin
      if (k < int'(nd)) frame[k+1] = ordered[k];
    end
    ppos = POS_W'(nd) + POS_W'(1);
    if (par_on) frame[ppos] = pval;
    nbits = NB_W'(1) + nd + NB_W'(par_on) + (two ? NB_W'(2) : NB_W'(1));
  end

endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift #(
  parameter int FRAME_W = 13,
  parameter int NB_W    = 4,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NB_W-1:0]    nbits,
  input  logic               half_last,
  input  logic               sync_mode,
  output logic               busy,
  output logic               txd
);

  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_FULL = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2 - 1);

  logic [FRAME_W-1:0] shreg;
  logic [NB_W-1:0]    left;
  logic [SUB_W-1:0]   sub;
  logic               half_q;
  logic               sync_q;
  logic               bit_end;

  always_comb begin
    bit_end = sync_q || (sub == SUB_FULL) ||
              (half_q && (left == NB_W'(1)) && (sub == SUB_HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '1;
      left   <= '0;
      sub    <= '0;
      half_q <= 1'b0;
      sync_q <= 1'b0;
    end else if (!en) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      sub   <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      shreg  <= frame;
      left   <= nbits;
      sub    <= '0;
      half_q <= half_last;
      sync_q <= sync_mode;
    end else if (busy && tick) begin
      if (bit_end) begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - NB_W'(1);
        sub   <= '0;
        if (left == NB_W'(1)) busy <= 1'b0;
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int OVS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic [1:0]          len_sel,
  input  logic                nine_bit,
  input  logic [2:0]          par_sel,
  input  logic                msb_first,
  input  logic [1:0]          stop_sel,
  input  logic                sync_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                txd,
  output logic                tx_empty
);

  localparam int FRAME_W = DATA_MAX + 4;
  localparam int NB_W    = $clog2(FRAME_W + 1);

  tx_mode_t            mode;
  logic                en_q;
  logic                hold_full;
  logic [DATA_MAX-1:0] hold_data;
  logic                busy;
  logic                load;
  logic [FRAME_W-1:0]  frame;
  logic [NB_W-1:0]     nbits;
  logic                half_last;

  assign mode = '{len: len_sel, nine: nine_bit, par: par_sel, msb: msb_first,
                  stop: stop_sel, sync: sync_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign load     = en & en_q & hold_full & ~busy;
  assign tx_empty = en_q & ~hold_full & ~busy;

  frame_tx_hold #(.DATA_MAX(DATA_MAX)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .en_q     (en_q),
    .in_valid (in_valid),
    .in_data  (in_data),
    .take     (load),
    .full     (hold_full),
    .ready    (in_ready),
    .data     (hold_data)
  );

  frame_tx_fmt #(.DATA_MAX(DATA_MAX), .FRAME_W(FRAME_W), .NB_W(NB_W)) u_fmt (
    .data      (hold_data),
    .mode      (mode),
    .frame     (frame),
    .nbits     (nbits),
    .half_last (half_last)
  );

  frame_tx_shift #(.FRAME_W(FRAME_W), .NB_W(NB_W), .OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .load      (load),
    .frame     (frame),
    .nbits     (nbits),
    .half_last (half_last),
    .sync_mode (sync_mode),
    .busy      (busy),
    .txd       (txd)
  );

endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int DATA_MAX = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                en_q,
  input logic                in_valid,
  input logic                in_ready,
  input logic                txd,
  input logic                tx_empty,
  input logic                busy,
  input logic                hold_full,
  input logic [DATA_MAX-1:0] hold_data
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en_q) |-> $past(txd));

  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_empty_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> in_ready);

  assert_drop_keeps_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && !in_ready && hold_full && busy) |=> (hold_full && $stable(hold_data)));

  assert_disable_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!in_ready && !tx_empty && txd));

endmodule

bind frame_tx frame_tx_chk #(.DATA_MAX(DATA_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .en_q      (en_q),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .txd       (txd),
  .tx_empty  (tx_empty),
  .busy      (busy),
  .hold_full (hold_full),
  .hold_data (hold_data)
);

// File: tb/frame_tx_bench.sv
module frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic       nine_bit = 1'b0;
  logic [2:0] par_sel = 3'd4;
  logic       msb_first = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic       sync_mode = 1'b1;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready, txd, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit got[$];
  bit exp_q[$];
  bit collecting = 0;
  bit seen_start = 0;

  frame_tx u_frame_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
    .len_sel(len_sel), .nine_bit(nine_bit), .par_sel(par_sel),
    .msb_first(msb_first), .stop_sel(stop_sel), .sync_mode(sync_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .tx_empty(tx_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // tick strobe and per-tick capture of txd
  always @(negedge clk) begin
    if (collecting && seen_start && tx_empty) collecting = 0;
    tick_cnt = tick_cnt + 1;
    tick = (tick_cnt >= tick_div);
    if (tick) tick_cnt = 0;
    if (collecting && tick) begin
      if (!seen_start && !txd) seen_start = 1;
      if (seen_start) got.push_back(txd);
    end
  end

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected per-tick waveform of one frame, from the requirements
  function automatic void add_frame(input logic [8:0] d);
    bit b[$];
    int n;
    bit p;
    bit half;
    int reps;
    n = nine_bit ? 9 : 5 + int'(len_sel);
    b.push_back(1'b0);
    for (int i = 0; i < n; i++) b.push_back(msb_first ? d[n-1-i] : d[i]);
    p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    case (par_sel)
      3'd0: b.push_back(p);
      3'd1: b.push_back(~p);
      3'd2: b.push_back(1'b0);
      3'd3: b.push_back(1'b1);
      default: ;
    endcase
    b.push_back(1'b1);
    if (stop_sel == 2'd2 || (stop_sel == 2'd1 && !sync_mode)) b.push_back(1'b1);
    half = (stop_sel == 2'd1) && !sync_mode;
    for (int j = 0; j < b.size(); j++) begin
      reps = sync_mode ? 1 : 16;
      if (half && j == b.size() - 1) reps = 8;
      for (int r = 0; r < reps; r++) exp_q.push_back(b[j]);
    end
  endfunction

  task automatic push(input logic [8:0] d);
    while (!in_ready) @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      if (bad < 0 && got[i] != exp_q[i]) bad = i;
    check(req, "frame tick count", got.size(), exp_q.size());
    check(req, "first mismatching tick", bad, -1);
  endtask

  task automatic run_one(input string req, input logic [8:0] d);
    got.delete();
    exp_q.delete();
    add_frame(d);
    seen_start = 0;
    collecting = 1;
    push(d);
    while (collecting) @(negedge clk);
    compare(req);
  endtask

  task automatic set_mode(input logic [1:0] l, input logic n9, input logic [2:0] p,
                          input logic m, input logic [1:0] s, input logic sy);
    len_sel = l; nine_bit = n9; par_sel = p; msb_first = m; stop_sel = s; sync_mode = sy;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "txd idle", txd, 1);
    check("R1", "ready while disabled", in_ready, 0);
    check("R1", "empty while disabled", tx_empty, 0);
    en = 1'b1;
    @(negedge clk);
    check("R1", "ready after enable", in_ready, 1);
    check("R1", "empty after enable", tx_empty, 1);

    // R2 / R5: sync, 8 bits, even parity, LSB first
    tick_div = 1;
    set_mode(2'd3, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1);
    run_one("R2", 9'h0A5);
    set_mode(2'd3, 1'b0, 3'd1, 1'b0, 2'd0, 1'b1);
    run_one("R5", 9'h0B7);
    // R3: async, 5 bits, odd parity, high bits ignored
    tick_div = 2;
    set_mode(2'd0, 1'b0, 3'd1, 1'b0, 2'd0, 1'b0);
    run_one("R3", 9'h1F3);
    set_mode(2'd2, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0);
    run_one("R3", 9'h1C9);
    // R4 / R6: nine-bit overrides length, mark parity, MSB first
    set_mode(2'd0, 1'b1, 3'd3, 1'b1, 2'd0, 1'b0);
    run_one("R4", 9'h135);
    set_mode(2'd1, 1'b0, 3'd5, 1'b1, 2'd0, 1'b1);
    run_one("R6", 9'h02D);
    // R7: stop bits
    set_mode(2'd3, 1'b0, 3'd2, 1'b0, 2'd1, 1'b0);
    run_one("R7", 9'h0FF);
    set_mode(2'd3, 1'b0, 3'd7, 1'b0, 2'd2, 1'b0);
    run_one("R7", 9'h066);
    set_mode(2'd3, 1'b0, 3'd7, 1'b0, 2'd1, 1'b1);
    run_one("R7", 9'h081);

    // R8 / R9 / R10: back-to-back with a dropped beat
    tick_div = 1;
    set_mode(2'd3, 1'b0, 3'd4, 1'b0, 2'd0, 1'b1);
    got.delete();
    exp_q.delete();
    add_frame(9'h03C);
    exp_q.push_back(1'b1);
    add_frame(9'h0C3);
    seen_start = 0;
    collecting = 1;
    push(9'h03C);
    check("R8", "ready after accept", in_ready, 0);
    @(negedge clk);
    check("R8", "ready after load", in_ready, 1);
    check("R9", "empty while shifting", tx_empty, 0);
    push(9'h0C3);
    check("R10", "ready while slot full", in_ready, 0);
    in_data  = 9'h1AA;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "empty with slot full", tx_empty, 0);
    while (collecting) @(negedge clk);
    compare("R10");
    check("R9", "empty after both frames", tx_empty, 1);

    // R11: disable mid-frame
    tick_div = 1;
    set_mode(2'd3, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0);
    push(9'h000);
    repeat (40) @(negedge clk);
    check("R11", "txd low in data", txd, 0);
    en = 1'b0;
    @(negedge clk);
    check("R11", "ready when disabled", in_ready, 0);
    check("R11", "empty when disabled", tx_empty, 0);
    check("R11", "txd when disabled", txd, 1);
    repeat (20) @(negedge clk);
    check("R11", "txd stays high", txd, 1);
    en = 1'b1;
    @(negedge clk);
    check("R1", "ready after re-enable", in_ready, 1);
    check("R11", "slot cleared by disable", tx_empty, 1);

    // R2: random modes and tick spacing
    for (int t = 0; t < 40; t++) begin
      tick_div = 1 + int'($urandom % 3);
      set_mode(2'($urandom), ($urandom % 4) == 0, 3'($urandom), 1'($urandom),
               2'($urandom % 3), 1'($urandom));
      run_one("R2", 9'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule